// File: doc/BRIEF.md
# Gray-Level Dot Mapper

This block sits between the pixel fetch and the panel data pins of a small grayscale LCD controller. Each clock it takes one 4-bit stored pixel and a flag saying whether that pixel lies inside the active display window. It applies the background, blanking and inversion overrides, then translates the resulting code through a 16-entry programmable gamma table into a 5-bit gray level.

A frame-rate-control stage turns that gray level into a single on/off dot for the current frame. A frame counter advances on each frame-start pulse and runs over a 32-frame cycle in 32-level mode, or over a 16-frame cycle in 16-level mode. The dot is on in frame `f` when the level is greater than the bit-reversed frame number. Because of this, over one full cycle the dot is on for exactly as many frames as the level.

The gamma table is written through a simple address/data port. A synchronous register-clear input returns the table and the frame counter to their defaults.

Top module: `gray_dot_mapper`

## Requirements
- R1: After `rst_ni` is released, `dot_o` is 0, the frame counter is 0, and gamma entries 0..15 hold 0, 2, 4, 6, 12, 13, 14, 15, 8, 9, 10, 11, 19, 23, 27, 31.
- R2: A gamma write (`lut_we_i` high) stores `lut_data_i` at `lut_addr_i` on that clock edge. Lookups from the next cycle onward use the new value.
- R3: With `lvl32_i`=1, `dot_o` is 1 when the 5-bit level is greater than the 5-bit bit-reversal of the frame counter. Over 32 consecutive frames the number of on frames equals the level.
- R4: With `lvl32_i`=0, only the low 4 bits of the level count, and they are compared with the 4-bit bit-reversal of the counter's low 4 bits. Over 16 frames the on count equals that 4-bit level.
- R5: The frame counter advances by one on each clock where `frame_start_i` is high, and otherwise holds. It wraps to 0 after 31 in 32-level mode, and after 15 or any larger value in 16-level mode.
- R6: A pixel with `in_window_i`=0 is replaced by `bg_color_i` before the gamma lookup.
- R7: With `reverse_i`=1, the code sent to the gamma lookup is 15 minus the code chosen by the window and blanking selection.
- R8: With `off_i`=1 and `reverse_i`=0, every pixel uses code 15 minus `bg_color_i`. With both bits at 1, every pixel uses `bg_color_i`.
- R9: `reg_clr_i` high at a clock edge restores every gamma entry to its R1 default and clears the frame counter. It takes priority over a gamma write and a frame start in the same cycle.
- R10: `dot_o` is registered. It reflects the inputs, table contents and frame counter present before the edge that updates it, and a level of 0 always yields a 0 dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_clr_i | input | 1 | Synchronous restore of table and counter defaults |
| lut_we_i | input | 1 | Gamma table write enable |
| lut_addr_i | input | 4 | Gamma table write address |
| lut_data_i | input | 5 | Gamma table write data |
| lvl32_i | input | 1 | 1: 32-level, 32-frame mode; 0: 16-level, 16-frame mode |
| reverse_i | input | 1 | Invert the displayed code |
| off_i | input | 1 | Blank the display to a background-derived code |
| bg_color_i | input | 4 | Background code |
| frame_start_i | input | 1 | Frame-start pulse, advances the frame counter |
| pix_i | input | 4 | Stored pixel code |
| in_window_i | input | 1 | Pixel lies inside the display window |
| dot_o | output | 1 | Registered on/off dot for the current frame |

## Verification
The assertions check the following on every cycle: the two blanking overrides of the selection stage, the counter hold, the counter's wrap in both modes, the clear of the counter, and the zero-level dark dot. Other behaviours can only be shown by the bench's scenarios, which compare every dot against a model of the table and counter. These include the default table contents, the one-cycle delay of a table write, the exact on/off pattern per frame, and the property that a full modulation cycle lights the dot for exactly the level's number of frames. They also include the 16-level mode's masking of a 5-bit entry and the priority of the register clear.

// File: rtl/gdm_pkg.sv
package gdm_pkg;
  localparam int PIX_W = 4;
  localparam int LVL_W = 5;

  function automatic logic [LVL_W-1:0] default_level(input int idx);
    case (idx)
      0: return 5'd0;   1: return 5'd2;   2: return 5'd4;   3: return 5'd6;
      4: return 5'd12;  5: return 5'd13;  6: return 5'd14;  7: return 5'd15;
      8: return 5'd8;   9: return 5'd9;   10: return 5'd10; 11: return 5'd11;
      12: return 5'd19; 13: return 5'd23; 14: return 5'd27; default: return 5'd31;
    endcase
  endfunction

  // reverse the low n bits of v, upper bits zero
  function automatic logic [LVL_W-1:0] bit_rev(input logic [LVL_W-1:0] v, input int n);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < LVL_W; i++)
      if (i < n) r[i] = v[n-1-i];
    return r;
  endfunction
endpackage

// File: rtl/gdm_lut.sv
module gdm_lut #(
  parameter int PIX_W = gdm_pkg::PIX_W,
  parameter int LVL_W = gdm_pkg::LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [PIX_W-1:0] wr_addr_i,
  input  logic [LVL_W-1:0] wr_data_i,
  input  logic [PIX_W-1:0] rd_addr_i,
  output logic [LVL_W-1:0] rd_lvl_o
);
  localparam int DEPTH = 1 << PIX_W;

  logic [LVL_W-1:0] lut_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        lut_q[g] <= gdm_pkg::default_level(g);
      else if (clr_i)
        lut_q[g] <= gdm_pkg::default_level(g);
      else if (we_i && (wr_addr_i == PIX_W'(g)))
        lut_q[g] <= wr_data_i;
    end
  end

  assign rd_lvl_o = lut_q[rd_addr_i];
endmodule

// File: rtl/gdm_mode_sel.sv
module gdm_mode_sel #(
  parameter int PIX_W = gdm_pkg::PIX_W
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic             in_window_i,
  input  logic             reverse_i,
  input  logic             off_i,
  input  logic [PIX_W-1:0] bg_i,
  output logic [PIX_W-1:0] code_o
);
  localparam logic [PIX_W-1:0] MAXC = {PIX_W{1'b1}};

  logic [PIX_W-1:0] base;

  always_comb begin
    if (off_i)            base = MAXC - bg_i;
    else if (in_window_i) base = pix_i;
    else                  base = bg_i;
    code_o = reverse_i ? (MAXC - base) : base;
  end
endmodule

// File: rtl/gdm_frc.sv
module gdm_frc #(
  parameter int LVL_W = gdm_pkg::LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             frame_start_i,
  input  logic             lvl32_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] cnt_o,
  output logic             dot_d_o
);
  localparam int SHORT_W = LVL_W - 1;
  localparam logic [LVL_W-1:0] TOP_LONG  = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] TOP_SHORT = {1'b0, {SHORT_W{1'b1}}};

  logic [LVL_W-1:0] cnt_q, top, pat, lvl_eff;

  assign top = lvl32_i ? TOP_LONG : TOP_SHORT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (frame_start_i) cnt_q <= (cnt_q >= top) ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    if (lvl32_i) begin
      pat     = gdm_pkg::bit_rev(cnt_q, LVL_W);
      lvl_eff = level_i;
    end else begin
      pat     = gdm_pkg::bit_rev({1'b0, cnt_q[SHORT_W-1:0]}, SHORT_W);
      lvl_eff = {1'b0, level_i[SHORT_W-1:0]};
    end
  end

  assign dot_d_o = lvl_eff > pat;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/gray_dot_mapper.sv
module gray_dot_mapper #(
  parameter int PIX_W = gdm_pkg::PIX_W,
  parameter int LVL_W = gdm_pkg::LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_clr_i,
  input  logic             lut_we_i,
  input  logic [PIX_W-1:0] lut_addr_i,
  input  logic [LVL_W-1:0] lut_data_i,
  input  logic             lvl32_i,
  input  logic             reverse_i,
  input  logic             off_i,
  input  logic [PIX_W-1:0] bg_color_i,
  input  logic             frame_start_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             in_window_i,
  output logic             dot_o
);
  logic [PIX_W-1:0] sel_code;
  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] frame_cnt;
  logic             dot_d;
  logic             dot_q;

  gdm_mode_sel #(.PIX_W(PIX_W)) u_sel (
    .pix_i       (pix_i),
    .in_window_i (in_window_i),
    .reverse_i   (reverse_i),
    .off_i       (off_i),
    .bg_i        (bg_color_i),
    .code_o      (sel_code)
  );

  gdm_lut #(.PIX_W(PIX_W), .LVL_W(LVL_W)) u_lut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (reg_clr_i),
    .we_i      (lut_we_i),
    .wr_addr_i (lut_addr_i),
    .wr_data_i (lut_data_i),
    .rd_addr_i (sel_code),
    .rd_lvl_o  (level)
  );

  gdm_frc #(.LVL_W(LVL_W)) u_frc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (reg_clr_i),
    .frame_start_i (frame_start_i),
    .lvl32_i       (lvl32_i),
    .level_i       (level),
    .cnt_o         (frame_cnt),
    .dot_d_o       (dot_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dot_q <= 1'b0;
    else         dot_q <= dot_d;
  end

  assign dot_o = dot_q;
endmodule

// File: rtl/gdm_checker.sv
module gdm_checker #(
  parameter int PIX_W = 4,
  parameter int LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_clr_i,
  input logic             frame_start_i,
  input logic             lvl32_i,
  input logic             off_i,
  input logic             reverse_i,
  input logic [PIX_W-1:0] bg_color_i,
  input logic [PIX_W-1:0] sel_code_i,
  input logic [LVL_W-1:0] level_i,
  input logic [LVL_W-1:0] cnt_i,
  input logic             dot_o
);
  localparam logic [PIX_W-1:0] MAXC = {PIX_W{1'b1}};
  localparam logic [LVL_W-1:0] TOP_LONG  = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] TOP_SHORT = {1'b0, {(LVL_W-1){1'b1}}};

  p_off_plain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i && !reverse_i |-> sel_code_i == MAXC - bg_color_i);

  p_off_rev_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i && reverse_i |-> sel_code_i == bg_color_i);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i && !reg_clr_i |=> $stable(cnt_i));

  p_wrap_long_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && lvl32_i && cnt_i == TOP_LONG |=> cnt_i == '0);

  p_wrap_short_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !lvl32_i && cnt_i >= TOP_SHORT |=> cnt_i == '0);

  p_clr_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_clr_i |=> cnt_i == '0);

  p_zero_dark_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i[LVL_W-2:0] == '0 && (!lvl32_i || !level_i[LVL_W-1]) |=> !dot_o);
endmodule

bind gray_dot_mapper gdm_checker #(.PIX_W(PIX_W), .LVL_W(LVL_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_clr_i     (reg_clr_i),
  .frame_start_i (frame_start_i),
  .lvl32_i       (lvl32_i),
  .off_i         (off_i),
  .reverse_i     (reverse_i),
  .bg_color_i    (bg_color_i),
  .sel_code_i    (sel_code),
  .level_i       (level),
  .cnt_i         (frame_cnt),
  .dot_o         (dot_o)
);

// File: tb/tb_gray_dot_mapper.sv
module tb_gray_dot_mapper;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni, reg_clr, lut_we, lvl32, reverse, off, fs, in_win;
  logic [3:0] lut_addr, bg, pix;
  logic [4:0] lut_data;
  logic       dot;

  gray_dot_mapper dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_clr_i(reg_clr), .lut_we_i(lut_we),
    .lut_addr_i(lut_addr), .lut_data_i(lut_data), .lvl32_i(lvl32),
    .reverse_i(reverse), .off_i(off), .bg_color_i(bg), .frame_start_i(fs),
    .pix_i(pix), .in_window_i(in_win), .dot_o(dot)
  );

  int checks = 0, errors = 0;
  logic [4:0] m_lut [16];
  logic [4:0] m_cnt;

  function automatic logic [4:0] dflt(int i);
    logic [4:0] t [16] = '{5'd0, 5'd2, 5'd4, 5'd6, 5'd12, 5'd13, 5'd14, 5'd15,
                           5'd8, 5'd9, 5'd10, 5'd11, 5'd19, 5'd23, 5'd27, 5'd31};
    return t[i];
  endfunction

  function automatic logic [4:0] rev(logic [4:0] v, int n);
    logic [4:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  function automatic logic [3:0] exp_code();
    logic [3:0] b;
    if (off) b = 4'd15 - bg;
    else if (in_win) b = pix;
    else b = bg;
    return reverse ? 4'd15 - b : b;
  endfunction

  function automatic logic exp_dot();
    logic [4:0] l = m_lut[exp_code()];
    if (lvl32) return l > rev(m_cnt, 5);
    return {1'b0, l[3:0]} > rev({1'b0, m_cnt[3:0]}, 4);
  endfunction

  function automatic string req_tag();
    if (off) return "R8";
    if (!in_win) return "R6";
    if (reverse) return "R7";
    return lvl32 ? "R3" : "R4";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_lut[i] = dflt(i);
    m_cnt = '0;
  endtask

  // one clock: inputs already driven; checks dot after the edge (R10)
  task automatic cyc(string req, output logic got);
    logic e = exp_dot();
    @(posedge clk);
    if (reg_clr) model_reset();
    else begin
      if (lut_we) m_lut[lut_addr] = lut_data;
      if (fs) m_cnt = (m_cnt >= (lvl32 ? 5'd31 : 5'd15)) ? 5'd0 : m_cnt + 5'd1;
    end
    @(negedge clk);
    got = dot;
    chk(req, int'(dot), int'(e));
  endtask

  task automatic idle();
    reg_clr = 0; lut_we = 0; fs = 0; off = 0; reverse = 0; in_win = 1;
  endtask

  task automatic count_cycle(logic mode32, logic [4:0] val, int exp_on, string req);
    logic g;
    int on = 0;
    idle(); reg_clr = 1; lvl32 = mode32; cyc("R9", g);
    reg_clr = 0; lut_we = 1; lut_addr = 4'd5; lut_data = val; cyc("R2", g);
    lut_we = 0; pix = 4'd5; fs = 1;
    for (int f = 0; f < (mode32 ? 32 : 16); f++) begin
      cyc(req, g);
      on += int'(g);
    end
    chk(req, on, exp_on);
    fs = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic g;
    void'($urandom(32'd1234));
    rst_ni = 0; idle(); lvl32 = 1; bg = 0; pix = 0;
    lut_addr = 0; lut_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", int'(dot), 0);
    rst_ni = 1;
    // R1: frame 0 pattern is 0, so dot = (default entry > 0)
    for (int p = 0; p < 16; p++) begin
      pix = 4'(p); cyc("R1", g);
      chk("R1", int'(g), (p == 0) ? 0 : 1);
    end
    // R2: write visible only from the next cycle
    pix = 4'd3; lut_we = 1; lut_addr = 4'd3; lut_data = 5'd0; cyc("R2", g);
    chk("R2", int'(g), 1);
    lut_we = 0; cyc("R2", g);
    chk("R2", int'(g), 0);
    // R3/R4: full-cycle on counts
    count_cycle(1'b1, 5'd0, 0, "R3");
    count_cycle(1'b1, 5'd1, 1, "R3");
    count_cycle(1'b1, 5'd17, 17, "R3");
    count_cycle(1'b1, 5'd31, 31, "R3");
    count_cycle(1'b0, 5'd9, 9, "R4");
    count_cycle(1'b0, 5'd15, 15, "R4");
    count_cycle(1'b0, 5'd19, 3, "R4");
    // R5: counter past 15 then switch to 16-level mode, wraps to 0
    idle(); lvl32 = 1; reg_clr = 1; cyc("R9", g); reg_clr = 0;
    fs = 1; repeat (20) cyc("R5", g);
    lvl32 = 0; cyc("R5", g); fs = 0; cyc("R5", g);
    // R8 off with and without reverse
    lvl32 = 1; off = 1; bg = 4'd2; cyc("R8", g);
    reverse = 1; cyc("R8", g);
    // R6/R7
    off = 0; reverse = 0; in_win = 0; bg = 4'd14; pix = 4'd0; cyc("R6", g);
    reverse = 1; cyc("R7", g); in_win = 1; pix = 4'd15; cyc("R7", g);
    // R9 priority over write and frame start
    idle(); lut_we = 1; lut_addr = 4'd0; lut_data = 5'd31; fs = 1; reg_clr = 1;
    pix = 4'd0; cyc("R9", g);
    idle(); cyc("R9", g);
    chk("R9", int'(g), 0);
    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      reg_clr  = ($urandom_range(0, 199) == 0);
      lut_we   = ($urandom_range(0, 9) == 0);
      lut_addr = 4'($urandom_range(0, 15));
      lut_data = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 99) == 0) lvl32 = ~lvl32;
      reverse  = ($urandom_range(0, 3) == 0);
      off      = ($urandom_range(0, 7) == 0);
      bg       = 4'($urandom_range(0, 15));
      fs       = ($urandom_range(0, 2) == 0);
      pix      = 4'($urandom_range(0, 15));
      in_win   = ($urandom_range(0, 4) != 0);
      cyc(req_tag(), g);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule